// File: doc/BRIEF.md
# Reset Pulse Stretcher and Cause Recorder

This block merges a chip's internal reset requests with a bidirectional, open-drain reset pin. Any accepted request, or the pin being pulled low from outside while the block is idle, starts one fixed sequence. The pin is driven low for a fixed number of clocks and then let go. After a further wait the block reads the pin back. If the pin is still low at that moment, an outside device is holding reset, and the cause is recorded as external. Otherwise the highest-ranked internal request seen during the sequence is recorded.

The internal reset output covers the whole sequence and drops one cycle after the read-back. The cause register is one-hot, so a later stage can pick a start address from it directly. The clock-monitor request counts only while the oscillator is enabled. The watchdog request counts only while its rate field is nonzero. Each request is taken on its rising edge, so a request held high does not keep the chip in reset.

Top module: `rst_pulse_gen`

## Requirements
- R1: While and after `rst_ni` is low, with no request and the pin high, `pin_drive_o`=0, `sys_rst_o`=0 and `cause_o`=0.
- R2: A rising edge on an accepted request sets `pin_drive_o` from the next clock edge E0 for exactly LOW_CYCLES (512) cycles. It falls at edge E0+LOW_CYCLES.
- R3: `sys_rst_o` rises at E0 together with `pin_drive_o`. It stays high until edge E0+LOW_CYCLES+WAIT_CYCLES+1 (E769).
- R4: The pin is read at edge E0+LOW_CYCLES+WAIT_CYCLES (E768), and `cause_o` is updated at that edge only.
- R5: `cause_o` is one-hot with bit0 power-on, bit1 low-voltage, bit2 clock monitor, bit3 watchdog, bit4 illegal address and bit5 external. Internal requests are latched across the sequence, and the lowest-numbered latched bit wins.
- R6: The clock-monitor request is ignored while `osc_en_i`=0. The watchdog request is ignored while `wd_rate_i`=0.
- R7: If `pin_i` is low at the read-back edge, or no internal request was latched, `cause_o` becomes 6'b100000 (external).
- R8: An accepted request arriving during the sequence restarts it: the pin is driven for LOW_CYCLES more cycles from the new request.
- R9: A request held high starts only one sequence. `pin_i` going low while the block is idle starts a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's own state |
| por_req_i | input | 1 | Power-on reset request |
| lvr_req_i | input | 1 | Low-voltage reset request |
| cm_req_i | input | 1 | Clock-monitor failure request |
| wd_req_i | input | 1 | Watchdog timeout request |
| ill_req_i | input | 1 | Illegal-address access request |
| osc_en_i | input | 1 | Oscillator enable, gates the clock-monitor request |
| wd_rate_i | input | 3 | Watchdog rate field, zero disables the watchdog request |
| pin_i | input | 1 | Level read back from the reset pin, 1 = high |
| pin_drive_o | output | 1 | Drive-low enable for the open-drain pin |
| sys_rst_o | output | 1 | Internal reset to the rest of the chip |
| cause_o | output | 6 | One-hot reset cause |

## Verification
Every result is tied to the edge E0 that first sees a request. The pin drive appears at E0 and ends at E0+512. The cause changes at E0+768. The internal reset drops at E0+769. The bench drives inputs on falling edges and counts falling edges from E0, so each check reads the outputs on the falling edge right after the edge where they are due. The last cycle before each change is checked as well. The restart case shifts all these points to the edge that sees the second request.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int NUM_INT = 5;
  localparam int CAUSE_W = NUM_INT + 1;
  localparam int IDX_POR = 0;
  localparam int IDX_LVR = 1;
  localparam int IDX_CM  = 2;
  localparam int IDX_WD  = 3;
  localparam int IDX_ILL = 4;
  localparam int IDX_EXT = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REL   = 2'd3
  } seq_state_e;

  // lowest index = highest rank
  function automatic logic [NUM_INT-1:0] pick_first(input logic [NUM_INT-1:0] v);
    logic [NUM_INT-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_INT; i++) begin
      if (v[i] && !found) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rstgen_req_gate.sv
module rstgen_req_gate
  import rstgen_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_req_i,
  input  logic               lvr_req_i,
  input  logic               cm_req_i,
  input  logic               wd_req_i,
  input  logic               ill_req_i,
  input  logic               osc_en_i,
  input  logic [RATE_W-1:0]  wd_rate_i,
  output logic [NUM_INT-1:0] new_req_o
);
  logic [NUM_INT-1:0] eff;
  logic [NUM_INT-1:0] prev_q;

  always_comb begin
    eff          = '0;
    eff[IDX_POR] = por_req_i;
    eff[IDX_LVR] = lvr_req_i;
    eff[IDX_CM]  = cm_req_i & osc_en_i;
    eff[IDX_WD]  = wd_req_i & (|wd_rate_i);
    eff[IDX_ILL] = ill_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= eff;
  end

  assign new_req_o = eff & ~prev_q;
endmodule

// File: rtl/rstgen_seq.sv
module rstgen_seq
  import rstgen_pkg::*;
#(
  parameter int LOW_CYCLES  = 512,
  parameter int WAIT_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_any_i,
  input  logic pin_i,
  output logic drive_o,
  output logic active_o,
  output logic sample_o
);
  localparam int MAXC  = (LOW_CYCLES > WAIT_CYCLES) ? LOW_CYCLES : WAIT_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYCLES - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              start;

  assign start    = req_any_i | ((state_q == ST_IDLE) & ~pin_i);
  assign sample_o = (state_q == ST_WAIT) & (cnt_q == WAIT_LAST) & ~req_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= ST_DRIVE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_DRIVE: begin
          if (cnt_q == LOW_LAST) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q == WAIT_LAST) begin
            state_q <= ST_REL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REL:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o  = (state_q == ST_DRIVE);
  assign active_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] new_req_i,
  input  logic               sample_i,
  input  logic               pin_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_INT-1:0] latched_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] next_cause;

  always_comb begin
    if (!pin_i || (latched_q == '0)) begin
      next_cause          = '0;
      next_cause[IDX_EXT] = 1'b1;
    end else begin
      next_cause = {1'b0, pick_first(latched_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_q <= '0;
      cause_q   <= '0;
    end else if (sample_i) begin
      latched_q <= '0;
      cause_q   <= next_cause;
    end else begin
      latched_q <= latched_q | new_req_i;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rstgen_pkg::*;
#(
  parameter int LOW_CYCLES  = 512,
  parameter int WAIT_CYCLES = 256,
  parameter int RATE_W      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_req_i,
  input  logic               lvr_req_i,
  input  logic               cm_req_i,
  input  logic               wd_req_i,
  input  logic               ill_req_i,
  input  logic               osc_en_i,
  input  logic [RATE_W-1:0]  wd_rate_i,
  input  logic               pin_i,
  output logic               pin_drive_o,
  output logic               sys_rst_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_INT-1:0] new_req;
  logic               sample;

  rstgen_req_gate #(.RATE_W(RATE_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_req_i (por_req_i),
    .lvr_req_i (lvr_req_i),
    .cm_req_i  (cm_req_i),
    .wd_req_i  (wd_req_i),
    .ill_req_i (ill_req_i),
    .osc_en_i  (osc_en_i),
    .wd_rate_i (wd_rate_i),
    .new_req_o (new_req)
  );

  rstgen_seq #(.LOW_CYCLES(LOW_CYCLES), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_any_i (|new_req),
    .pin_i     (pin_i),
    .drive_o   (pin_drive_o),
    .active_o  (sys_rst_o),
    .sample_o  (sample)
  );

  rstgen_cause u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_req_i (new_req),
    .sample_i  (sample),
    .pin_i     (pin_i),
    .cause_o   (cause_o)
  );
endmodule

// File: rtl/rst_pulse_gen_chk.sv
module rst_pulse_gen_chk #(
  parameter int RATE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_req_i,
  input logic              lvr_req_i,
  input logic              cm_req_i,
  input logic              wd_req_i,
  input logic              ill_req_i,
  input logic              osc_en_i,
  input logic [RATE_W-1:0] wd_rate_i,
  input logic              pin_i,
  input logic              pin_drive_o,
  input logic              sys_rst_o,
  input logic [5:0]        cause_o
);
  p_drive_in_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> sys_rst_o);

  p_por_starts_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_req_i) |=> pin_drive_o);

  p_rel_keeps_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> sys_rst_o);

  p_cause_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));

  p_cause_at_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cause_o) |-> (sys_rst_o && !pin_drive_o));

  // R6: a sequence only starts from an accepted request or a low pin
  p_rst_has_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(por_req_i || lvr_req_i || ill_req_i ||
                               (cm_req_i && osc_en_i) ||
                               (wd_req_i && (wd_rate_i != '0)) || !pin_i));
endmodule

bind rst_pulse_gen rst_pulse_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_req_i   (por_req_i),
  .lvr_req_i   (lvr_req_i),
  .cm_req_i    (cm_req_i),
  .wd_req_i    (wd_req_i),
  .ill_req_i   (ill_req_i),
  .osc_en_i    (osc_en_i),
  .wd_rate_i   (wd_rate_i),
  .pin_i       (pin_i),
  .pin_drive_o (pin_drive_o),
  .sys_rst_o   (sys_rst_o),
  .cause_o     (cause_o)
);

// File: tb/tb_rst_pulse_gen.sv
module tb_rst_pulse_gen;
  localparam int LOW  = 512;
  localparam int WAIT = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por = 0, lvr = 0, cm = 0, wd = 0, ill = 0, osc_en = 0;
  logic [2:0] rate = 3'd0;
  logic ext_hold = 0;
  logic pin;
  logic drive, sys_rst;
  logic [5:0] cause;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign pin = ~(drive | ext_hold);

  rst_pulse_gen dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .por_req_i(por), .lvr_req_i(lvr), .cm_req_i(cm), .wd_req_i(wd), .ill_req_i(ill),
    .osc_en_i(osc_en), .wd_rate_i(rate), .pin_i(pin),
    .pin_drive_o(drive), .sys_rst_o(sys_rst), .cause_o(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at the negedge before E0; requests are one-cycle pulses already set
  task automatic run_seq(input logic [5:0] exp_cause, input logic [5:0] old_cause);
    step(1);
    por = 0; lvr = 0; cm = 0; ill = 0;
    chk("R2 drive at E0", drive, 1);
    chk("R3 rst at E0", sys_rst, 1);
    step(LOW - 1);
    chk("R2 drive last cycle", drive, 1);
    step(1);
    chk("R2 drive released", drive, 0);
    chk("R3 rst held in wait", sys_rst, 1);
    step(WAIT - 1);
    chk("R4 cause before sample", cause, old_cause);
    step(1);
    chk("R4/R5 cause at sample", cause, exp_cause);
    chk("R3 rst one after sample", sys_rst, 1);
    step(1);
    chk("R3 rst released", sys_rst, 0);
  endtask

  task automatic t_reset;
    chk("R1 drive in reset", drive, 0);
    chk("R1 rst in reset", sys_rst, 0);
    chk("R1 cause in reset", cause, 0);
    rst_ni = 1;
    step(3);
    chk("R1 idle drive", drive, 0);
    chk("R1 idle rst", sys_rst, 0);
    chk("R1 idle cause", cause, 0);
  endtask

  task automatic t_por;
    por = 1;
    run_seq(6'b000001, 6'b000000);
  endtask

  task automatic t_priority;
    osc_en = 1; rate = 3'd2;
    wd = 1; cm = 1; ill = 1;
    run_seq(6'b000100, 6'b000001);
    wd = 0; step(2);
    lvr = 1; ill = 1; wd = 1;
    run_seq(6'b000010, 6'b000100);
    wd = 0; step(2);
  endtask

  task automatic t_gating;
    osc_en = 0; cm = 1;
    step(1); cm = 0; step(4);
    chk("R6 clock monitor ignored, rst", sys_rst, 0);
    chk("R6 clock monitor ignored, cause", cause, 6'b000010);
    rate = 3'd0; wd = 1;
    step(1); wd = 0; step(4);
    chk("R6 watchdog ignored, rst", sys_rst, 0);
    chk("R6 watchdog ignored, drive", drive, 0);
  endtask

  task automatic t_external;
    // R9 pin pulled low from outside while idle, released before sample
    ext_hold = 1;
    step(1);
    chk("R9 external start", drive, 1);
    step(2); ext_hold = 0;
    step(LOW - 3);
    chk("R2 ext drive last", drive, 1);
    step(1);
    chk("R2 ext drive released", drive, 0);
    step(WAIT);
    chk("R7 external cause", cause, 6'b100000);
    step(1);
    chk("R3 ext rst released", sys_rst, 0);
    // R7 internal request but pin held low past the sample point
    por = 1; ext_hold = 1;
    step(1); por = 0;
    step(LOW + WAIT - 1);
    chk("R7 pre-sample cause", cause, 6'b100000);
    step(1);
    chk("R7 held pin overrides internal", cause, 6'b100000);
    ext_hold = 0;
    step(1);
    chk("R7 rst released", sys_rst, 0);
    step(2);
    chk("R7 no retrigger", sys_rst, 0);
  endtask

  task automatic t_restart;
    lvr = 1;
    step(1); lvr = 0;
    chk("R8 first drive", drive, 1);
    step(299);
    ill = 1;
    step(1); ill = 0;
    step(LOW - 1);
    chk("R8 drive extended", drive, 1);
    step(1);
    chk("R8 drive ends after restart", drive, 0);
    step(WAIT - 1);
    chk("R8 cause before sample", cause, 6'b100000);
    step(1);
    chk("R8/R5 latched across restart", cause, 6'b000010);
    step(1);
    chk("R8 rst released", sys_rst, 0);
  endtask

  task automatic t_level;
    rate = 3'd5; wd = 1;
    step(1);
    chk("R9 held watchdog starts", drive, 1);
    step(LOW + WAIT);
    chk("R9 watchdog cause", cause, 6'b001000);
    step(1);
    chk("R9 rst released", sys_rst, 0);
    step(50);
    chk("R9 held request no restart", sys_rst, 0);
    wd = 0;
  endtask

  initial begin
    step(4);
    t_reset();
    t_por();
    t_priority();
    t_gating();
    t_external();
    t_restart();
    t_level();
    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule